// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a direct-mapped cache with a small fully associative victim buffer beside it. The processor side presents one block-sized request at a time: a read or a full-block write to a block address. The low address bits select a main-cache line and the remaining bits form its tag. A hit in the main cache answers immediately. On a main-cache miss, the victim buffer is searched by the full block address.

When the victim buffer holds the block, the two lines swap places. The requested block moves into the main cache, and the line it displaces takes over the exact buffer slot the requested block left. No memory access occurs. When neither structure holds the block, it is read from memory. The displaced main-cache line then goes into the buffer's least recently used slot, and a dirty line pushed out of the buffer by that insertion is written back.

Each response carries one of three status flags: main-cache hit, victim-buffer hit, or memory fill. A bench can count each class from these flags.

Top module: `dmvc_cache`

## Requirements
- R1: After reset, every line of both structures is empty, `req_ready` is 1, and `resp_valid`, `mem_rd_req` and `mem_wr_valid` are 0.
- R2: A request whose block is in the main cache gets `resp_valid` with `resp_main_hit`=1 on the clock edge after it is accepted. `resp_rdata` is the block after the access: the stored data for a read, `req_wdata` for a write.
- R3: A request that misses in both structures raises `mem_rd_req` for exactly one cycle, on the edge after acceptance, with `mem_rd_addr` equal to the request address. `req_ready` stays 0 until the response.
- R4: A fill response comes on the edge after `mem_rd_valid`, with `resp_mem_fill`=1. For a read, `resp_rdata` is `mem_rd_data`. For a write, it is `req_wdata`.
- R5: On a fill, a valid displaced main-cache line is inserted into the buffer slot that is least recently used. That slot then becomes most recently used.
- R6: A request that misses in the main cache but hits in the victim buffer gets `resp_victim_hit`=1 on the edge after acceptance, with no memory read. The displaced main-cache line takes the slot the requested block came from.
- R7: A victim-buffer hit does not change the buffer's recency order, so the least recently used entry is never evicted by it.
- R8: When an insertion replaces a dirty buffer entry, `mem_wr_valid` pulses for one cycle together with the fill response, carrying that entry's address and data. Replacing a clean or empty entry causes no write.
- R9: A block's dirty state moves with it between the main cache and the buffer in both directions.
- R10: Two blocks mapping to the same main-cache line can alternate accesses with no memory read once both are held between the two structures.
- R11: Every response asserts exactly one of `resp_main_hit`, `resp_victim_hit` and `resp_mem_fill`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = full-block write, 0 = read |
| req_addr | input | ADDR_W | Block address; low IDX_W bits select the main line |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Response present for one cycle |
| resp_rdata | output | DATA_W | Block contents after the access |
| resp_main_hit | output | 1 | Served by the main cache |
| resp_victim_hit | output | 1 | Served by a swap with the victim buffer |
| resp_mem_fill | output | 1 | Served from memory |
| mem_rd_req | output | 1 | One-cycle block read request |
| mem_rd_addr | output | ADDR_W | Block address to read |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | DATA_W | Returned block |
| mem_wr_valid | output | 1 | One-cycle write-back of a dirty buffer entry |
| mem_wr_addr | output | ADDR_W | Write-back address |
| mem_wr_data | output | DATA_W | Write-back data |

## Verification
The bench builds the cache with 4 main lines (IDX_W=2), 8-bit block addresses, 16-bit data and the default two buffer entries. With this setup, four blocks that share line 0 cover every buffer outcome within a dozen accesses: swaps in both directions, an insertion into an empty slot, clean and dirty evictions, and a victim hit on the slot that is least recently used. Because the buffer is small, a swap that wrongly changed the recency order would evict the wrong block on the next fill. The bench sees that as a later victim hit turning into a fill. A dirty block written back and then fetched again confirms the written-back data.

// File: rtl/dmvc_pkg.sv
package dmvc_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } dmvc_state_e;
endpackage

// File: rtl/dmvc_lru.sv
module dmvc_lru #(
    parameter  int N  = 2,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch,
    input  logic [SW-1:0] touch_idx,
    output logic [SW-1:0] lru_idx
);
    logic [SW-1:0] age_q [N];
    logic [SW-1:0] age_d [N];
    logic [N-1:0]  oldest;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            age_d[i] = age_q[i];
            if (touch) begin
                if (SW'(i) == touch_idx)
                    age_d[i] = '0;
                else if (age_q[i] < age_q[touch_idx])
                    age_d[i] = age_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < N; i++) begin
            oldest[i] = (age_q[i] == SW'(N - 1));
            if (oldest[i]) lru_idx = SW'(i);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) age_q[i] <= SW'(i);
            else        age_q[i] <= age_d[i];
        end
    end

    // R5: the recency ages always form a permutation with one oldest slot
    a_r5_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest) == 1);
    // R5: a touched slot is no longer the replacement candidate
    a_r5_touch_mru: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> lru_idx != $past(touch_idx));
endmodule

// File: rtl/dmvc_vbuf.sv
module dmvc_vbuf #(
    parameter  int N      = 2,
    parameter  int ADDR_W = 10,
    parameter  int DATA_W = 32,
    localparam int SW     = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              hit,
    output logic              hit_dirty,
    output logic [DATA_W-1:0] hit_data,
    input  logic              put_en,
    input  logic              put_swap,
    input  logic              put_valid,
    input  logic              put_dirty,
    input  logic [ADDR_W-1:0] put_addr,
    input  logic [DATA_W-1:0] put_data,
    output logic              lru_valid,
    output logic              lru_dirty,
    output logic [ADDR_W-1:0] lru_addr,
    output logic [DATA_W-1:0] lru_data
);
    logic              val_q [N], val_d [N];
    logic              drt_q [N], drt_d [N];
    logic [ADDR_W-1:0] adr_q [N], adr_d [N];
    logic [DATA_W-1:0] dat_q [N], dat_d [N];
    logic [N-1:0]      match;
    logic [SW-1:0]     hit_slot;
    logic [SW-1:0]     lru_idx;
    logic [SW-1:0]     put_slot;

    dmvc_lru #(.N(N)) u_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .touch    (put_en && !put_swap),
        .touch_idx(lru_idx),
        .lru_idx  (lru_idx)
    );

    always_comb begin
        hit_slot = '0;
        for (int i = 0; i < N; i++) begin
            match[i] = val_q[i] && (adr_q[i] == look_addr);
            if (match[i]) hit_slot = SW'(i);
        end
        hit       = |match;
        hit_dirty = drt_q[hit_slot];
        hit_data  = dat_q[hit_slot];
        lru_valid = val_q[lru_idx];
        lru_dirty = drt_q[lru_idx];
        lru_addr  = adr_q[lru_idx];
        lru_data  = dat_q[lru_idx];
        put_slot  = put_swap ? hit_slot : lru_idx;
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            val_d[i] = val_q[i];
            drt_d[i] = drt_q[i];
            adr_d[i] = adr_q[i];
            dat_d[i] = dat_q[i];
            if (put_en && (SW'(i) == put_slot)) begin
                val_d[i] = put_valid;
                drt_d[i] = put_dirty;
                adr_d[i] = put_addr;
                dat_d[i] = put_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                val_q[i] <= 1'b0;
                drt_q[i] <= 1'b0;
                adr_q[i] <= '0;
                dat_q[i] <= '0;
            end else begin
                val_q[i] <= val_d[i];
                drt_q[i] <= drt_d[i];
                adr_q[i] <= adr_d[i];
                dat_q[i] <= dat_d[i];
            end
        end
    end

    // R6: a block address is held in at most one slot
    a_r6_unique_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match) <= 1);
    // R6: a swap only happens on a lookup that hit
    a_r6_swap_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        put_en && put_swap |-> hit);
    // R7: a swap leaves the replacement candidate where it was
    a_r7_swap_keeps_lru: assert property (@(posedge clk) disable iff (!rst_n)
        put_en && put_swap |=> $stable(lru_idx));
endmodule

// File: rtl/dmvc_cache.sv
module dmvc_cache
    import dmvc_pkg::*;
#(
    parameter  int ADDR_W = 10,
    parameter  int IDX_W  = 4,
    parameter  int DATA_W = 32,
    parameter  int VB_N   = 2,
    localparam int SETS   = 1 << IDX_W,
    localparam int TAG_W  = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              resp_main_hit,
    output logic              resp_victim_hit,
    output logic              resp_mem_fill,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);
    typedef struct packed {
        dmvc_state_e       st;
        logic [ADDR_W-1:0] p_addr;
        logic              p_write;
        logic [DATA_W-1:0] p_wdata;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_data;
        logic              k_main;
        logic              k_vic;
        logic              k_fill;
        logic              rd_req;
        logic              wr_v;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
    } ctl_t;

    ctl_t s_q, s_d;
    logic             lv_q [SETS], lv_d [SETS];
    logic             ld_q [SETS], ld_d [SETS];
    logic [TAG_W-1:0] lt_q [SETS], lt_d [SETS];
    logic [DATA_W-1:0] lx_q [SETS], lx_d [SETS];

    logic [IDX_W-1:0]  r_idx, f_idx;
    logic [TAG_W-1:0]  r_tag, f_tag;
    logic              main_hit;
    logic [ADDR_W-1:0] look_addr;
    logic              vb_hit, vb_hit_dirty;
    logic [DATA_W-1:0] vb_hit_data;
    logic              put_en, put_swap, put_valid, put_dirty;
    logic [ADDR_W-1:0] put_addr;
    logic [DATA_W-1:0] put_data;
    logic              lru_valid, lru_dirty;
    logic [ADDR_W-1:0] lru_addr;
    logic [DATA_W-1:0] lru_data;

    assign r_idx    = req_addr[IDX_W-1:0];
    assign r_tag    = req_addr[ADDR_W-1:IDX_W];
    assign f_idx    = s_q.p_addr[IDX_W-1:0];
    assign f_tag    = s_q.p_addr[ADDR_W-1:IDX_W];
    assign main_hit = lv_q[r_idx] && (lt_q[r_idx] == r_tag);

    dmvc_vbuf #(.N(VB_N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_vbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_addr (look_addr),
        .hit       (vb_hit),
        .hit_dirty (vb_hit_dirty),
        .hit_data  (vb_hit_data),
        .put_en    (put_en),
        .put_swap  (put_swap),
        .put_valid (put_valid),
        .put_dirty (put_dirty),
        .put_addr  (put_addr),
        .put_data  (put_data),
        .lru_valid (lru_valid),
        .lru_dirty (lru_dirty),
        .lru_addr  (lru_addr),
        .lru_data  (lru_data)
    );

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < SETS; i++) begin
            lv_d[i] = lv_q[i];
            ld_d[i] = ld_q[i];
            lt_d[i] = lt_q[i];
            lx_d[i] = lx_q[i];
        end
        s_d.rsp_v  = 1'b0;
        s_d.k_main = 1'b0;
        s_d.k_vic  = 1'b0;
        s_d.k_fill = 1'b0;
        s_d.rd_req = 1'b0;
        s_d.wr_v   = 1'b0;
        put_en     = 1'b0;
        put_swap   = 1'b0;
        put_valid  = 1'b0;
        put_dirty  = 1'b0;
        put_addr   = '0;
        put_data   = '0;
        look_addr  = req_addr;
        case (s_q.st)
            ST_IDLE: if (req_valid) begin
                if (main_hit) begin
                    if (req_write) begin
                        lx_d[r_idx] = req_wdata;
                        ld_d[r_idx] = 1'b1;
                    end
                    s_d.rsp_v    = 1'b1;
                    s_d.k_main   = 1'b1;
                    s_d.rsp_data = req_write ? req_wdata : lx_q[r_idx];
                end else if (vb_hit) begin
                    put_en    = 1'b1;
                    put_swap  = 1'b1;
                    put_valid = lv_q[r_idx];
                    put_dirty = ld_q[r_idx];
                    put_addr  = {lt_q[r_idx], r_idx};
                    put_data  = lx_q[r_idx];
                    lv_d[r_idx] = 1'b1;
                    lt_d[r_idx] = r_tag;
                    ld_d[r_idx] = vb_hit_dirty || req_write;
                    lx_d[r_idx] = req_write ? req_wdata : vb_hit_data;
                    s_d.rsp_v    = 1'b1;
                    s_d.k_vic    = 1'b1;
                    s_d.rsp_data = req_write ? req_wdata : vb_hit_data;
                end else begin
                    s_d.st      = ST_FILL;
                    s_d.p_addr  = req_addr;
                    s_d.p_write = req_write;
                    s_d.p_wdata = req_wdata;
                    s_d.rd_req  = 1'b1;
                end
            end
            ST_FILL: begin
                look_addr = s_q.p_addr;
                if (mem_rd_valid) begin
                    if (lv_q[f_idx]) begin
                        put_en    = 1'b1;
                        put_valid = 1'b1;
                        put_dirty = ld_q[f_idx];
                        put_addr  = {lt_q[f_idx], f_idx};
                        put_data  = lx_q[f_idx];
                        if (lru_valid && lru_dirty) begin
                            s_d.wr_v    = 1'b1;
                            s_d.wr_addr = lru_addr;
                            s_d.wr_data = lru_data;
                        end
                    end
                    lv_d[f_idx] = 1'b1;
                    lt_d[f_idx] = f_tag;
                    ld_d[f_idx] = s_q.p_write;
                    lx_d[f_idx] = s_q.p_write ? s_q.p_wdata : mem_rd_data;
                    s_d.rsp_v    = 1'b1;
                    s_d.k_fill   = 1'b1;
                    s_d.rsp_data = s_q.p_write ? s_q.p_wdata : mem_rd_data;
                    s_d.st       = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int i = 0; i < SETS; i++) begin
                lv_q[i] <= 1'b0;
                ld_q[i] <= 1'b0;
                lt_q[i] <= '0;
                lx_q[i] <= '0;
            end
        end else begin
            s_q <= s_d;
            for (int i = 0; i < SETS; i++) begin
                lv_q[i] <= lv_d[i];
                ld_q[i] <= ld_d[i];
                lt_q[i] <= lt_d[i];
                lx_q[i] <= lx_d[i];
            end
        end
    end

    assign req_ready       = (s_q.st == ST_IDLE);
    assign resp_valid      = s_q.rsp_v;
    assign resp_rdata      = s_q.rsp_data;
    assign resp_main_hit   = s_q.k_main;
    assign resp_victim_hit = s_q.k_vic;
    assign resp_mem_fill   = s_q.k_fill;
    assign mem_rd_req      = s_q.rd_req;
    assign mem_rd_addr     = s_q.p_addr;
    assign mem_wr_valid    = s_q.wr_v;
    assign mem_wr_addr     = s_q.wr_addr;
    assign mem_wr_data     = s_q.wr_data;

    // R11: each response names exactly one source
    a_r11_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $onehot({resp_main_hit, resp_victim_hit, resp_mem_fill}));
    // R3: the memory read is a single pulse while requests are held off
    a_r3_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);
    a_r3_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !req_ready);
    // R8: write-backs only accompany a fill response
    a_r8_wb_with_fill: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> resp_valid && resp_mem_fill);
    // R6: a victim hit or main hit never starts a memory read
    a_r6_no_read_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_mem_fill |-> !mem_rd_req);
endmodule

// File: tb/sim_dmvc_cache.sv
`timescale 1ns/1ps
module sim_dmvc_cache;
    localparam int AW = 8;
    localparam int IW = 2;
    localparam int DW = 16;
    localparam int K_MAIN = 0;
    localparam int K_VIC  = 1;
    localparam int K_FILL = 2;

    typedef struct packed {
        logic [1:0]    kind;
        logic [DW-1:0] data;
        logic          wb;
        logic [AW-1:0] wb_addr;
        logic [DW-1:0] wb_data;
        logic [7:0]    tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, resp_valid, resp_main_hit, resp_victim_hit, resp_mem_fill;
    logic [DW-1:0] resp_rdata;
    logic mem_rd_req, mem_wr_valid;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;
    logic [DW-1:0] mem_wr_data;
    logic mem_rd_valid = 1'b0;
    logic [DW-1:0] mem_rd_data = '0;

    int total = 0, bad = 0, cycles = 0, reads = 0;
    logic [DW-1:0] mem [256];
    logic [DW-1:0] shadow [256];
    exp_t q[$];

    always #2.5 clk = ~clk;

    dmvc_cache #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW), .VB_N(2)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .resp_main_hit(resp_main_hit), .resp_victim_hit(resp_victim_hit),
        .resp_mem_fill(resp_mem_fill), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .mem_wr_valid(mem_wr_valid),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    task automatic check(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model: answers a read three cycles later, absorbs write-backs
    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]    = 16'(i * 37 + 16'h1000);
            shadow[i] = mem[i];
        end
    end
    int lat = 0;
    logic [AW-1:0] rd_a = '0;
    always @(negedge clk) begin
        mem_rd_valid <= 1'b0;
        if (mem_wr_valid) mem[mem_wr_addr] = mem_wr_data;
        if (mem_rd_req) begin
            reads++;
            rd_a = mem_rd_addr;
            lat  = 3;
        end else if (lat > 0) begin
            lat--;
            if (lat == 0) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= mem[rd_a];
            end
        end
    end

    // Monitor: compares each response against the queued expectation
    always @(negedge clk) begin
        if (resp_valid) begin
            if (q.size() == 0) begin
                check("R11 unexpected response", 1'b0, 32'(resp_rdata), 32'h0);
            end else begin
                exp_t e;
                logic [2:0] kflags;
                e = q.pop_front();
                kflags = {resp_mem_fill, resp_victim_hit, resp_main_hit};
                check($sformatf("R11/kind step %0d", e.tag), kflags == 3'(1 << e.kind),
                      32'(kflags), 32'(1 << e.kind));
                check($sformatf("R2/R4/R6 data step %0d", e.tag), resp_rdata == e.data,
                      32'(resp_rdata), 32'(e.data));
                check($sformatf("R8 wb strobe step %0d", e.tag), mem_wr_valid == e.wb,
                      32'(mem_wr_valid), 32'(e.wb));
                if (e.wb && mem_wr_valid)
                    check($sformatf("R8 wb addr/data step %0d", e.tag),
                          mem_wr_addr == e.wb_addr && mem_wr_data == e.wb_data,
                          {8'h0, mem_wr_addr, mem_wr_data}, {8'h0, e.wb_addr, e.wb_data});
            end
        end
    end

    // Driver: issues one access, queues its expectation, waits for the answer
    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input int kind, input logic wb, input logic [AW-1:0] wba, input logic [7:0] step);
        exp_t e;
        while (!req_ready) @(negedge clk);
        if (wr) shadow[a] = wd;
        e.kind = 2'(kind); e.data = shadow[a]; e.wb = wb; e.wb_addr = wba;
        e.wb_data = shadow[wba]; e.tag = step;
        q.push_back(e);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        // R3: read pulse appears exactly when both structures miss
        check($sformatf("R3 rd_req step %0d", step), mem_rd_req == (kind == K_FILL),
              32'(mem_rd_req), 32'(kind == K_FILL));
        if (kind == K_FILL) begin
            check($sformatf("R3 rd_addr step %0d", step), mem_rd_addr == a, 32'(mem_rd_addr), 32'(a));
            check($sformatf("R3 busy step %0d", step), req_ready == 1'b0, 32'(req_ready), 32'h0);
        end
        while (q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check("R1 ready", req_ready == 1'b1, 32'(req_ready), 32'h1);
        check("R1 quiet", {resp_valid, mem_rd_req, mem_wr_valid} == 3'b000,
              32'({resp_valid, mem_rd_req, mem_wr_valid}), 32'h0);
        // Blocks 00, 04, 08, 0C all share main line 0
        access(0, 8'h00, 0,       K_FILL, 0, 0, 1);  // R1 empty, R4
        access(0, 8'h00, 0,       K_MAIN, 0, 0, 2);  // R2
        access(1, 8'h00, 16'h1111, K_MAIN, 0, 0, 3); // R2 write
        access(0, 8'h04, 0,       K_FILL, 0, 0, 4);  // R5 00 into buffer
        access(0, 8'h00, 0,       K_VIC,  0, 0, 5);  // R6 R9 swap
        access(0, 8'h04, 0,       K_VIC,  0, 0, 6);  // R10 swap back
        check("R10 no memory reads", reads == 2, 32'(reads), 32'd2);
        access(0, 8'h08, 0,       K_FILL, 0, 0, 7);  // R5 04 into empty slot
        access(0, 8'h00, 0,       K_VIC,  0, 0, 8);  // R7 hit on oldest slot
        access(0, 8'h0C, 0,       K_FILL, 0, 0, 9);  // R7 08 clean evicted
        access(0, 8'h08, 0,       K_FILL, 0, 0, 10); // R5 04 evicted, 0C kept
        access(0, 8'h04, 0,       K_FILL, 1, 8'h00, 11); // R8 R9 dirty 00 written
        access(0, 8'h00, 0,       K_FILL, 0, 0, 12); // R8 data came back
        access(1, 8'h05, 16'hBEEF, K_FILL, 0, 0, 13); // R4 write miss
        access(0, 8'h05, 0,       K_MAIN, 0, 0, 14); // R2
        repeat (3) @(negedge clk);
        check("R8 no stray write", mem_wr_valid == 1'b0, 32'(mem_wr_valid), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule